// File: doc/BRIEF.md
# Two-Wire Block-Write Configuration Receiver

This block is a receive-only slave on a two-wire serial bus (clock line and data line, both open drain). It watches the bus with the system clock and accepts one kind of transaction: a block write. A block write carries a fixed slave address with the write direction, then a command byte, then a byte count, then that many payload bytes. The payload bytes are stored one after another into a small bank of 8-bit control registers, always starting at register 0. The registers drive a set of output-enable controls in parallel.

Both bus lines pass through a synchronizer and a majority filter before start and stop conditions are detected, so pulses as short as one system clock are removed. The slave acknowledges each byte it accepts by pulling the data line low for the ninth clock. An address that does not match, a read request, a zero count, a count above the block limit, and payload bytes past the declared count are all left unacknowledged. After such a refusal the slave ignores the bus until the next start. A stop may arrive after any complete byte. Bytes already acknowledged stay written, and the registers after them keep their old contents.

The command byte is acknowledged and kept on its own output. It has no effect on where payload bytes land. The clock line is never held low, and the slave never returns data. The system clock must run at least 20 times faster than the bus clock, which covers both the 100 kbit/s and the 400 kbit/s bus rates.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every byte of `cfg_regs_o` is 0xFF, `cmd_code_o` is 0x00 and `sda_drive_o` is 0.
- R2: The only first byte acknowledged after a start is 0xD2 (7-bit address 0x69 followed by direction bit 0). Any other first byte, including the read form 0xD3, is not acknowledged, and every following byte is ignored and not acknowledged until the next start.
- R3: `sda_drive_o` goes to 1 only while the filtered clock line is low, after the falling edge that ends the eighth bit of an accepted byte. It returns to 0 while the clock line is low, after the falling edge that ends the ninth clock.
- R4: The byte after the address is always acknowledged and appears on `cmd_code_o` once that byte's ninth clock ends. Its value does not move the write position: the first payload byte still goes to register 0.
- R5: A byte count of 0 is not acknowledged. No payload byte that follows is acknowledged, and no register changes.
- R6: A byte count above 32 is not acknowledged and changes no register. A count of 32 is accepted and fills registers 0 to 31.
- R7: Payload byte k (counting from 0) is acknowledged and written to register k, which is bits 8k+7 down to 8k of `cfg_regs_o`.
- R8: If a stop ends a transfer after fewer payload bytes than the count, the acknowledged bytes stay written and all higher registers keep their previous values.
- R9: Payload bytes beyond the declared count are not acknowledged, and no register takes their value.
- R10: A repeated start in the middle of a transfer returns the slave to the address phase. The next accepted transfer writes again from register 0.
- R11: A pulse on SDA or SCL that lasts one system clock is removed by the filter. Such a pulse creates no start, no stop and no extra bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the bus clock rate |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_o | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_regs_o | output | 256 | Register bank, register k in bits 8k+7:8k |
| cmd_code_o | output | 8 | Command byte of the last accepted transfer |

## Verification
The checker watches, on every cycle, that the acknowledge drive only switches while the filtered clock is low and stays off in the idle and refusal states. It also checks that registers change only on a write strobe issued in the payload phase with count remaining, and that the command output holds outside the command phase. Whether a given byte is acknowledged, which register ends up with which value, how an early stop or a repeated start leaves the bank, and whether one-cycle glitches are rejected can only be shown by the bench's transfer scenarios, which compare the bank against a model after each transfer.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

   // Receive phases of the block-write slave
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_CMD    = 3'd2,
      ST_COUNT  = 3'd3,
      ST_DATA   = 3'd4,
      ST_IGNORE = 3'd5
   } smb_state_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int TAPS        = 3,
   parameter bit IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic filt_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("smb_line_filter: SYNC_STAGES must be at least 2");
   end
   if (TAPS < 1 || (TAPS % 2) == 0) begin : g_bad_taps
      $error("smb_line_filter: TAPS must be odd and positive");
   end

   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   if (TAPS == 1) begin : g_no_vote
      // Single tap: synchronized level registered once more
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) filt_o <= IDLE_LEVEL;
         else        filt_o <= sync_q[SYNC_STAGES-1];
      end
   end else begin : g_vote
      logic [TAPS-1:0] taps_q;
      logic            vote;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) taps_q <= {TAPS{IDLE_LEVEL}};
         else        taps_q <= {taps_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      end

      assign vote = ($countones(taps_q) > (TAPS / 2));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) filt_o <= IDLE_LEVEL;
         else        filt_o <= vote;
      end
   end

endmodule

// File: rtl/smb_cond_detect.sv
module smb_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f_i,
   input  logic sda_f_i,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);

   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f_i;
         sda_d <= sda_f_i;
      end
   end

   // Data edges count as conditions only while the clock stays high
   assign start_o    = scl_f_i & scl_d & sda_d & ~sda_f_i;
   assign stop_o     = scl_f_i & scl_d & ~sda_d & sda_f_i;
   assign scl_rise_o = scl_f_i & ~scl_d;
   assign scl_fall_o = ~scl_f_i & scl_d;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
   parameter int           NUM_REGS   = 32,
   parameter logic [7:0]   RESET_BYTE = 8'hFF,
   localparam int          IDX_W      = $clog2(NUM_REGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic [IDX_W-1:0]      wr_idx_i,
   input  logic [7:0]            wr_data_i,
   output logic [NUM_REGS*8-1:0] regs_o
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RESET_BYTE;
         else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
            q <= wr_data_i;
      end
      assign regs_o[g*8 +: 8] = q;
   end

endmodule

// File: rtl/smb_rx_fsm.sv
module smb_rx_fsm
   import smb_cfg_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h69,
   parameter int         NUM_REGS   = 32,
   parameter int         MAX_COUNT  = 32,
   localparam int        IDX_W      = $clog2(NUM_REGS),
   localparam int        CNT_W      = $clog2(MAX_COUNT + 1),
   localparam int        PTR_W      = (CNT_W > IDX_W + 1) ? CNT_W : IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_f_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             scl_rise_i,
   input  logic             scl_fall_i,
   output logic             sda_drive_o,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [7:0]       wr_data_o,
   output logic [7:0]       cmd_code_o,
   output smb_state_e       state_o,
   output logic             remain_nz_o
);

   localparam logic [7:0]       ADDR_BYTE  = {SLAVE_ADDR, 1'b0};
   localparam logic [7:0]       MAX_BYTE   = 8'(MAX_COUNT);
   localparam logic [PTR_W-1:0] REG_LIMIT  = PTR_W'(NUM_REGS);
   localparam logic [3:0]       LAST_BIT   = 4'd8;

   smb_state_e       state_q;
   logic [3:0]       bit_q;
   logic [7:0]       shreg_q;
   logic             in_ack_q;
   logic             acc_q;
   logic [CNT_W-1:0] remain_q;
   logic [PTR_W-1:0] ptr_q;
   logic [7:0]       cmd_q;
   logic             drive_q;
   logic             active;
   logic             byte_ok;

   assign active = (state_q != ST_IDLE) && (state_q != ST_IGNORE);

   // Acceptance decision for the byte just shifted in
   always_comb begin
      unique case (state_q)
         ST_ADDR:  byte_ok = (shreg_q == ADDR_BYTE);
         ST_CMD:   byte_ok = 1'b1;
         ST_COUNT: byte_ok = (shreg_q != 8'd0) && (shreg_q <= MAX_BYTE);
         ST_DATA:  byte_ok = (remain_q != '0);
         default:  byte_ok = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bit_q    <= '0;
         shreg_q  <= '0;
         in_ack_q <= 1'b0;
         acc_q    <= 1'b0;
         remain_q <= '0;
         ptr_q    <= '0;
         cmd_q    <= '0;
         drive_q  <= 1'b0;
      end else if (start_i) begin
         // Start or repeated start: back to the address phase
         state_q  <= ST_ADDR;
         bit_q    <= '0;
         in_ack_q <= 1'b0;
         drive_q  <= 1'b0;
      end else if (stop_i) begin
         state_q  <= ST_IDLE;
         bit_q    <= '0;
         in_ack_q <= 1'b0;
         drive_q  <= 1'b0;
      end else if (active) begin
         if (scl_rise_i && !in_ack_q && (bit_q != LAST_BIT)) begin
            shreg_q <= {shreg_q[6:0], sda_f_i};
            bit_q   <= bit_q + 4'd1;
         end
         if (scl_fall_i) begin
            if (in_ack_q) begin
               // Ninth clock finished: release the line and act on the byte
               in_ack_q <= 1'b0;
               drive_q  <= 1'b0;
               bit_q    <= '0;
               if (!acc_q) begin
                  state_q <= ST_IGNORE;
               end else begin
                  unique case (state_q)
                     ST_ADDR: state_q <= ST_CMD;
                     ST_CMD: begin
                        cmd_q   <= shreg_q;
                        state_q <= ST_COUNT;
                     end
                     ST_COUNT: begin
                        remain_q <= shreg_q[CNT_W-1:0];
                        ptr_q    <= '0;
                        state_q  <= ST_DATA;
                     end
                     ST_DATA: begin
                        remain_q <= remain_q - 1'b1;
                        ptr_q    <= ptr_q + 1'b1;
                     end
                     default: state_q <= ST_IGNORE;
                  endcase
               end
            end else if (bit_q == LAST_BIT) begin
               in_ack_q <= 1'b1;
               acc_q    <= byte_ok;
               drive_q  <= byte_ok;
            end
         end
      end
   end

   assign wr_en_o     = active && !start_i && !stop_i && scl_fall_i && in_ack_q &&
                        acc_q && (state_q == ST_DATA) && (ptr_q < REG_LIMIT);
   assign wr_idx_o    = ptr_q[IDX_W-1:0];
   assign wr_data_o   = shreg_q;
   assign cmd_code_o  = cmd_q;
   assign sda_drive_o = drive_q;
   assign state_o     = state_q;
   assign remain_nz_o = (remain_q != '0);

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
   import smb_cfg_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR  = 7'h69,
   parameter int         NUM_REGS    = 32,
   parameter int         MAX_COUNT   = 32,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILTER_TAPS = 3,
   parameter logic [7:0] RESET_BYTE  = 8'hFF,
   localparam int        IDX_W       = $clog2(NUM_REGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_drive_o,
   output logic [NUM_REGS*8-1:0] cfg_regs_o,
   output logic [7:0]            cmd_code_o
);

   if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_regs
      $error("smb_cfg_slave: NUM_REGS must lie in 2..256");
   end
   if (MAX_COUNT < 1 || MAX_COUNT > 255) begin : g_bad_count
      $error("smb_cfg_slave: MAX_COUNT must lie in 1..255");
   end

   logic       scl_filt, sda_filt;
   logic       start_ev, stop_ev, scl_rise, scl_fall;
   logic       wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0] wr_data;
   smb_state_e fsm_state;
   logic       remain_nz;

   smb_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .TAPS        (FILTER_TAPS),
      .IDLE_LEVEL  (1'b1)
   ) u_scl_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (scl_i),
      .filt_o (scl_filt)
   );

   smb_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .TAPS        (FILTER_TAPS),
      .IDLE_LEVEL  (1'b1)
   ) u_sda_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (sda_i),
      .filt_o (sda_filt)
   );

   smb_cond_detect u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_f_i    (scl_filt),
      .sda_f_i    (sda_filt),
      .start_o    (start_ev),
      .stop_o     (stop_ev),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall)
   );

   smb_rx_fsm #(
      .SLAVE_ADDR (SLAVE_ADDR),
      .NUM_REGS   (NUM_REGS),
      .MAX_COUNT  (MAX_COUNT)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sda_f_i     (sda_filt),
      .start_i     (start_ev),
      .stop_i      (stop_ev),
      .scl_rise_i  (scl_rise),
      .scl_fall_i  (scl_fall),
      .sda_drive_o (sda_drive_o),
      .wr_en_o     (wr_en),
      .wr_idx_o    (wr_idx),
      .wr_data_o   (wr_data),
      .cmd_code_o  (cmd_code_o),
      .state_o     (fsm_state),
      .remain_nz_o (remain_nz)
   );

   smb_reg_bank #(
      .NUM_REGS   (NUM_REGS),
      .RESET_BYTE (RESET_BYTE)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (wr_data),
      .regs_o    (cfg_regs_o)
   );

endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
   import smb_cfg_pkg::*;
#(
   parameter int NUM_REGS = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sda_drive_o,
   input logic [NUM_REGS*8-1:0] cfg_regs_o,
   input logic [7:0]            cmd_code_o,
   input logic                  scl_f,
   input smb_state_e            state,
   input logic                  wr_en,
   input logic                  remain_nz
);

   logic was_rst;
   always_ff @(posedge clk) was_rst <= !rst_n;

   // R1: bank all ones, command cleared, line released while held in reset
   always @(posedge clk) begin
      if (was_rst && !rst_n) begin
         assert_reset_ones_R1: assert (cfg_regs_o == '1 && cmd_code_o == 8'h00 && !sda_drive_o)
            else $error("reset state wrong");
      end
   end

   // R3: acknowledge drive switches on only while the clock line is low
   assert_ack_on_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_o) |-> !scl_f);

   // R3: acknowledge drive switches off only while the clock line is low
   assert_ack_off_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_drive_o) |-> !scl_f);

   // R2/R5: no acknowledge while idle or after a refusal
   assert_quiet_when_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_IGNORE) |-> !sda_drive_o);

   // R7: register writes only in the payload phase
   assert_write_in_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (state == ST_DATA));

   // R9: no write once the declared count is used up
   assert_write_within_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> remain_nz);

   // R8: the bank holds unless a write strobe was issued
   assert_regs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_regs_o));

   // R4: command output changes only out of the command phase
   assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_CMD) |=> $stable(cmd_code_o));

endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sda_drive_o (sda_drive_o),
   .cfg_regs_o  (cfg_regs_o),
   .cmd_code_o  (cmd_code_o),
   .scl_f       (scl_filt),
   .state       (fsm_state),
   .wr_en       (wr_en),
   .remain_nz   (remain_nz)
);

// File: tb/tb_smb_cfg_slave.sv
`timescale 1ns/1ps
module tb_smb_cfg_slave;

   localparam int Q    = 10;   // system clocks per quarter bus bit
   localparam int NREG = 32;
   localparam int MAXC = 32;
   localparam int NVEC = 9;

   // {first byte, command, count, payload bytes sent}
   localparam logic [31:0] VECS [NVEC] = '{
      32'hD2_01_03_03,   // plain write of 3
      32'hD2_02_01_01,   // single byte
      32'hD2_03_20_20,   // full 32-byte block
      32'hD2_04_05_02,   // early stop after 2 of 5
      32'hD3_05_02_02,   // read request
      32'hA4_06_02_02,   // wrong address
      32'hD2_07_00_02,   // zero count
      32'hD2_08_21_02,   // count 33
      32'hD2_09_02_04    // extra bytes past count
   };

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_h = 1'b1, sda_h = 1'b1, sda_gl = 1'b0, scl_gl = 1'b0;
   logic             sda_drive;
   logic [NREG*8-1:0] regs;
   logic [7:0]       cmd;
   logic             scl_line, sda_line;

   assign scl_line = scl_h | scl_gl;
   assign sda_line = sda_h & ~sda_drive & ~sda_gl;

   smb_cfg_slave dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_line),
      .sda_i       (sda_line),
      .sda_drive_o (sda_drive),
      .cfg_regs_o  (regs),
      .cmd_code_o  (cmd)
   );

   int errs = 0, checks = 0;
   logic [7:0] mdl [NREG];
   logic [7:0] mcmd;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_h = 1'b1; wq();
      scl_h = 1'b1; wq();
      sda_h = 1'b0; wq();
      scl_h = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wq();
      scl_h = 1'b1; wq();
      sda_h = 1'b1; wq();
      repeat (20) @(negedge clk);
   endtask

   // Sends one byte; returns 1 when the line was low in the ninth clock.
   task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_h = b[i];
         if (glitch && i == 5) begin
            repeat (4) @(negedge clk);
            scl_gl = 1'b1; @(negedge clk); scl_gl = 1'b0;
            repeat (Q - 5) @(negedge clk);
         end else wq();
         scl_h = 1'b1;
         if (glitch && i == 3) begin
            repeat (4) @(negedge clk);
            sda_gl = 1'b1; @(negedge clk); sda_gl = 1'b0;
            repeat (Q - 5) @(negedge clk);
         end else wq();
         wq();
         scl_h = 1'b0; wq();
      end
      sda_h = 1'b1; wq();
      scl_h = 1'b1; wq();
      ack = !sda_line;
      wq();
      scl_h = 1'b0; wq();
      check(sda_drive == 1'b0, "R3 release after ninth clock", int'(sda_drive), 0);
   endtask

   task automatic compare_bank(input string tag);
      int bad = -1;
      for (int i = NREG - 1; i >= 0; i--)
         if (regs[i*8 +: 8] !== mdl[i]) bad = i;
      if (bad < 0) check(1'b1, tag, 0, 0);
      else check(1'b0, tag, int'(regs[bad*8 +: 8]), int'(mdl[bad]));
   endtask

   function automatic logic [7:0] data_of(input int v, input int i);
      return 8'((v * 37 + i * 11 + 5) ^ 8'hA5);
   endfunction

   task automatic run_vec(input int v, input logic [31:0] vec);
      logic [7:0] a_b, c_b, n_b, s_b;
      bit ack, a_ok, n_ok, exp;
      string tag;
      a_b = vec[31:24]; c_b = vec[23:16]; n_b = vec[15:8]; s_b = vec[7:0];
      a_ok = (a_b == 8'hD2);
      n_ok = a_ok && (n_b >= 8'd1) && (n_b <= 8'(MAXC));
      bus_start();
      send_byte(a_b, 1'b0, ack);
      check(ack == a_ok, "R2 address ack", int'(ack), int'(a_ok));
      send_byte(c_b, 1'b0, ack);
      check(ack == a_ok, a_ok ? "R4 command ack" : "R2 command ignored", int'(ack), int'(a_ok));
      send_byte(n_b, 1'b0, ack);
      tag = !a_ok ? "R2 count ignored" : (n_b == 0) ? "R5 zero count" :
            (n_b > MAXC) ? "R6 count limit" : "R6 count accepted";
      check(ack == n_ok, tag, int'(ack), int'(n_ok));
      if (a_ok) mcmd = c_b;
      for (int i = 0; i < int'(s_b); i++) begin
         exp = n_ok && (i < int'(n_b));
         send_byte(data_of(v, i), 1'b0, ack);
         tag = !a_ok ? "R2 data ignored" : (n_b == 0) ? "R5 data ignored" :
               (n_b > MAXC) ? "R6 data ignored" : (i >= int'(n_b)) ? "R9 extra byte" : "R7 data ack";
         check(ack == exp, tag, int'(ack), int'(exp));
         if (exp) mdl[i] = data_of(v, i);
      end
      bus_stop();
      compare_bank((v == 3) ? "R8 early stop bank" : "R7 bank contents");
      check(cmd == mcmd, "R4 command value", int'(cmd), int'(mcmd));
   endtask

   initial begin
      bit ack;
      for (int i = 0; i < NREG; i++) mdl[i] = 8'hFF;
      mcmd = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      compare_bank("R1 reset bank");
      check(cmd == 8'h00, "R1 reset command", int'(cmd), 0);
      check(sda_drive == 1'b0, "R1 reset drive", int'(sda_drive), 0);

      for (int v = 0; v < NVEC; v++) run_vec(v, VECS[v]);

      // R10: repeated start mid-payload, second transfer restarts at register 0
      bus_start();
      send_byte(8'hD2, 1'b0, ack);
      send_byte(8'h20, 1'b0, ack);
      send_byte(8'h03, 1'b0, ack);
      send_byte(8'h3C, 1'b0, ack);
      send_byte(8'h4D, 1'b0, ack);
      mdl[0] = 8'h3C; mdl[1] = 8'h4D;
      bus_start();
      send_byte(8'hD2, 1'b0, ack);
      check(ack == 1'b1, "R10 address after repeated start", int'(ack), 1);
      send_byte(8'h21, 1'b0, ack);
      send_byte(8'h01, 1'b0, ack);
      send_byte(8'h77, 1'b0, ack);
      check(ack == 1'b1, "R10 data ack", int'(ack), 1);
      mdl[0] = 8'h77; mcmd = 8'h21;
      bus_stop();
      compare_bank("R10 restart writes register 0");
      check(cmd == 8'h21, "R10 command", int'(cmd), 8'h21);

      // R11: one-clock glitches on both lines inside a payload byte
      bus_start();
      send_byte(8'hD2, 1'b0, ack);
      send_byte(8'h30, 1'b0, ack);
      send_byte(8'h02, 1'b0, ack);
      send_byte(8'hFF, 1'b1, ack);
      check(ack == 1'b1, "R11 glitched byte ack", int'(ack), 1);
      send_byte(8'h5A, 1'b1, ack);
      check(ack == 1'b1, "R11 second glitched byte ack", int'(ack), 1);
      mdl[0] = 8'hFF; mdl[1] = 8'h5A; mcmd = 8'h30;
      bus_stop();
      compare_bank("R11 bank after glitches");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule